// File: doc/BRIEF.md
# Memory Controller Status Register File

This block is the bus-facing register slave of one memory controller. A bus master issues single read or write requests carrying a byte address, an access size and 32-bit write data. The block decodes the longword offset into four control and status registers (A, B, C, D) or into a small configuration ROM window. Each register applies its own read mask and write mask. Some fields change only when an enable bit in the same write data is set. The error flags clear when a one is written to them.

A mode pin chooses a basic or an extended build. It is sampled only while reset is asserted. The mode selects the reset contents of A and B, the read and clear masks of C, and whether register D exists at all. Error events from the memory array set flags in C and D through two set-vector inputs. A separate byte-write port fills the ROM.

Every accepted request is answered exactly one cycle later, with a read-valid or write-acknowledge pulse. A non-existent-location pulse or an error-confirmation pulse accompanies that answer when the access is refused.

Top module: `memctl_csr_file`

## Requirements
- R1: When reset is released in basic mode, A reads 0x00007E10, B reads 0x00003000 OR (CTRL_IDX shifted left by 21), and C reads 0. No response output is active.
- R2: When reset is released in extended mode, A reads ((ARRAY_MB-1) shifted left by 9) OR 0x6A. B reads 0x00003000 OR ((CTRL_IDX*ARRAY_MB) shifted left by 19). C and D read 0.
- R3: Longword offset = byte address bits ADDR_W-1:2. Offsets 0, 1, 2 and 3 select A, B, C and D. A read at offset 0x400+k returns ROM word k when k < ROM_WORDS, and gives a non-existent-location response otherwise.
- R4: An access is refused when address bits 1:0 are not 00, or when req_size_i is not 2 (0 = byte, 1 = word, 2 = longword). A refused access changes no state and pulses err_cnf_o together with its handshake, with read data 0.
- R5: A write to A always loads bit 8. It loads bits 2:0 only when bit 8 of the write data is 1. A reads are masked with 0x00107FFF.
- R6: A write to B always loads bits 14 and 9:0. It loads bits 27:15 only when bit 14 of the write data is 1. B reads return (stored AND 0xFFFFF7FF) OR 0x00003000.
- R7: In basic mode, a write to C loads bit 30 from the data and then clears every bit of 0x30000000 where the data has a 1. C reads are masked with 0x7FFFFFFF.
- R8: In extended mode, C and D both follow the R7 write rule but with the clear mask 0x300C0380. Both read through the mask 0x700C0380.
- R9: In basic mode, a read or write of offset 3 gives a non-existent-location response and has no effect.
- R10: Offsets below 0x400 other than 0 to 3, and every write to the ROM window, give a non-existent-location response and change no state.
- R11: A ROM byte write to byte address b replaces byte lane b[1:0] (bits 8*lane+7:8*lane) of ROM word b[ROM_AW+1:2] and keeps the other three bytes.
- R12: A request accepted at a clock edge produces exactly one rsp_valid_o pulse (read) or wr_ack_o pulse (write) in the following cycle. Read data is 0 whenever nxm_o or err_cnf_o is set. Reads return the state from before any same-cycle update.
- R13: Each 1 in err_set_c_i (or in err_set_d_i in extended mode) sets that flag bit, except bit 30, which only a bus write can change. When a set and a write-one-to-clear hit the same bit in the same cycle, the set wins.
- R14: Changing ext_mode_i while reset is deasserted has no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, also samples the mode |
| ext_mode_i | input | 1 | 1 = extended build, 0 = basic build |
| req_valid_i | input | 1 | Request present this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte address inside the controller window |
| req_size_i | input | 2 | Access size: 0 byte, 1 word, 2 longword |
| req_wdata_i | input | 32 | Write data |
| err_set_c_i | input | 32 | Error events to set in C |
| err_set_d_i | input | 32 | Error events to set in D |
| rom_wr_en_i | input | 1 | ROM byte write strobe |
| rom_wr_addr_i | input | ROM_AW+2 | ROM byte address |
| rom_wr_byte_i | input | 8 | ROM byte value |
| rsp_valid_o | output | 1 | Read response pulse |
| wr_ack_o | output | 1 | Write acknowledge pulse |
| rsp_rdata_o | output | 32 | Read data |
| nxm_o | output | 1 | Non-existent location pulse |
| err_cnf_o | output | 1 | Bad size or alignment pulse |

## Verification
The hardest cases to reach are collisions inside one cycle: an error event setting the same C or D bit that a write-one-to-clear is clearing, and a ROM byte write landing on the word that a bus read is fetching. The directed part of the stimulus builds both collisions on purpose. A pseudo-random phase in each mode then mixes register, ROM, undefined-offset and misaligned accesses with sparse error-set vectors. Mode retention is reached by toggling the mode pin after reset and probing register D.

// File: rtl/memctl_pkg.sv
package memctl_pkg;

  localparam int unsigned ROM_BASE_OFS = 32'h400;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef enum logic [2:0] {
    SEL_NONE = 3'd0,
    SEL_A    = 3'd1,
    SEL_B    = 3'd2,
    SEL_C    = 3'd3,
    SEL_D    = 3'd4,
    SEL_ROM  = 3'd5
  } reg_sel_e;

  localparam logic [31:0] A_RD_MASK   = 32'h0010_7FFF;
  localparam logic [31:0] A_ILV_EN    = 32'h0000_0100;
  localparam logic [31:0] A_ILV       = 32'h0000_0007;
  localparam logic [31:0] A_SIZE_BAS  = 32'h0000_7E00;
  localparam logic [31:0] A_TYPE_BAS  = 32'h0000_0010;
  localparam logic [31:0] A_TYPE_EXT  = 32'h0000_006A;
  localparam logic [31:0] B_RD_MASK   = 32'hFFFF_F7FF;
  localparam logic [31:0] B_INIT      = 32'h0000_3000;
  localparam logic [31:0] B_FIXED_WR  = 32'h0000_43FF;
  localparam logic [31:0] B_SA_EN     = 32'h0000_4000;
  localparam logic [31:0] B_SA        = 32'h0FFF_8000;
  localparam logic [31:0] FLAG_DCRD   = 32'h4000_0000;
  localparam logic [31:0] W1C_BAS     = 32'h3000_0000;
  localparam logic [31:0] W1C_EXT     = 32'h300C_0380;
  localparam logic [31:0] ERR_RD_BAS  = 32'h7FFF_FFFF;
  localparam logic [31:0] ERR_RD_EXT  = 32'h700C_0380;

  function automatic logic [31:0] a_reset_val(logic ext, int unsigned mb);
    return ext ? (((32'(mb) - 32'd1) << 9) | A_TYPE_EXT) : (A_SIZE_BAS | A_TYPE_BAS);
  endfunction

  function automatic logic [31:0] b_reset_val(logic ext, int unsigned idx, int unsigned mb);
    return ext ? (B_INIT | ((32'(idx) * 32'(mb)) << 19)) : (B_INIT | (32'(idx) << 21));
  endfunction

  function automatic logic [31:0] merge_bits(logic [31:0] old, logic [31:0] wd, logic [31:0] mask);
    return (old & ~mask) | (wd & mask);
  endfunction

  function automatic logic [31:0] a_wr_mask(logic [31:0] wd);
    return A_ILV_EN | (((wd & A_ILV_EN) != 32'd0) ? A_ILV : 32'd0);
  endfunction

  function automatic logic [31:0] b_wr_mask(logic [31:0] wd);
    return B_FIXED_WR | (((wd & B_SA_EN) != 32'd0) ? B_SA : 32'd0);
  endfunction

  function automatic logic [31:0] clr_mask(logic ext);
    return ext ? W1C_EXT : W1C_BAS;
  endfunction

  function automatic logic [31:0] err_rd_mask(logic ext);
    return ext ? ERR_RD_EXT : ERR_RD_BAS;
  endfunction

  // Write first (load disable bit, then clear ones), set events last so they win.
  function automatic logic [31:0] flag_next(logic [31:0] old, logic [31:0] wd, logic we,
                                            logic [31:0] w1c, logic [31:0] set);
    logic [31:0] n;
    n = old;
    if (we) n = merge_bits(old, wd, FLAG_DCRD) & ~(wd & w1c);
    return n | (set & ~FLAG_DCRD);
  endfunction

endpackage

// File: rtl/memctl_decode.sv
module memctl_decode
  import memctl_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int ROM_WORDS = 16,
  localparam int OFS_W    = ADDR_W - 2,
  localparam int ROM_AW   = $clog2(ROM_WORDS)
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  acc_size_e         size_i,
  input  logic              write_i,
  input  logic              ext_i,
  output reg_sel_e          sel_o,
  output logic              bad_o,
  output logic              nxm_o,
  output logic [ROM_AW-1:0] rom_idx_o
);

  localparam logic [OFS_W-1:0] ROM_BASE = OFS_W'(ROM_BASE_OFS);
  localparam logic [OFS_W-1:0] ROM_LIM  = OFS_W'(ROM_WORDS);

  logic [OFS_W-1:0] ofs;
  logic [OFS_W-1:0] rel;

  assign ofs       = addr_i[ADDR_W-1:2];
  assign rel       = ofs - ROM_BASE;
  assign rom_idx_o = rel[ROM_AW-1:0];

  always_comb begin
    sel_o = SEL_NONE;
    nxm_o = 1'b0;
    bad_o = (addr_i[1:0] != 2'b00) || (size_i != SZ_LONG);
    if (!bad_o) begin
      if (ofs >= ROM_BASE) begin
        if (write_i || (rel >= ROM_LIM)) nxm_o = 1'b1;
        else                             sel_o = SEL_ROM;
      end else begin
        case (ofs)
          OFS_W'(0): sel_o = SEL_A;
          OFS_W'(1): sel_o = SEL_B;
          OFS_W'(2): sel_o = SEL_C;
          OFS_W'(3): begin
            if (ext_i) sel_o = SEL_D;
            else       nxm_o = 1'b1;
          end
          default:   nxm_o = 1'b1;
        endcase
      end
    end
  end

endmodule

// File: rtl/memctl_regs.sv
module memctl_regs
  import memctl_pkg::*;
#(
  parameter int CTRL_IDX = 1,
  parameter int ARRAY_MB = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ext_mode_i,
  input  logic        wr_fire_i,
  input  reg_sel_e    sel_i,
  input  logic [31:0] wdata_i,
  input  logic [31:0] set_c_i,
  input  logic [31:0] set_d_i,
  output logic        ext_q_o,
  output logic [31:0] rd_a_o,
  output logic [31:0] rd_b_o,
  output logic [31:0] rd_c_o,
  output logic [31:0] rd_d_o
);

  logic        ext_q;
  logic [31:0] a_q, b_q, c_q, d_q;
  logic        wr_a, wr_b, wr_c, wr_d;

  assign wr_a = wr_fire_i && (sel_i == SEL_A);
  assign wr_b = wr_fire_i && (sel_i == SEL_B);
  assign wr_c = wr_fire_i && (sel_i == SEL_C);
  assign wr_d = wr_fire_i && (sel_i == SEL_D);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ext_q <= ext_mode_i;
      a_q   <= a_reset_val(ext_mode_i, ARRAY_MB);
      b_q   <= b_reset_val(ext_mode_i, CTRL_IDX, ARRAY_MB);
      c_q   <= '0;
      d_q   <= '0;
    end else begin
      if (wr_a) a_q <= merge_bits(a_q, wdata_i, a_wr_mask(wdata_i));
      if (wr_b) b_q <= merge_bits(b_q, wdata_i, b_wr_mask(wdata_i));
      c_q <= flag_next(c_q, wdata_i, wr_c, clr_mask(ext_q), set_c_i);
      d_q <= ext_q ? flag_next(d_q, wdata_i, wr_d, W1C_EXT, set_d_i) : '0;
    end
  end

  assign ext_q_o = ext_q;
  assign rd_a_o  = a_q & A_RD_MASK;
  assign rd_b_o  = (b_q & B_RD_MASK) | B_INIT;
  assign rd_c_o  = c_q & err_rd_mask(ext_q);
  assign rd_d_o  = d_q & ERR_RD_EXT;

  // R14: the mode latched at reset never moves afterwards
  p_mode_hold_r14: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(ext_q));

  // R5: interleave field guarded by its enable bit
  p_ilv_guard_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_a && ((wdata_i & A_ILV_EN) == 32'd0)) |=> ((a_q & A_ILV) == $past(a_q & A_ILV)));

  // R6: start-address field guarded by its enable bit
  p_sa_guard_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_b && ((wdata_i & B_SA_EN) == 32'd0)) |=> ((b_q & B_SA) == $past(b_q & B_SA)));

  // R13: disable bit of C changes only on a bus write to C
  p_dcrd_sw_only_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_c |=> ((c_q & FLAG_DCRD) == $past(c_q & FLAG_DCRD)));

  // R9: register D holds nothing in the basic build
  p_d_absent_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_q |-> (d_q == 32'd0));

endmodule

// File: rtl/memctl_rom.sv
module memctl_rom #(
  parameter int ROM_WORDS = 16,
  localparam int ROM_AW   = $clog2(ROM_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ROM_AW+1:0] wr_addr_i,
  input  logic [7:0]        wr_byte_i,
  input  logic [ROM_AW-1:0] rd_idx_i,
  output logic [31:0]       rd_data_o
);

  logic [31:0]       mem [ROM_WORDS];
  logic [ROM_AW-1:0] wr_idx;
  logic [1:0]        wr_lane;

  assign wr_idx  = wr_addr_i[ROM_AW+1:2];
  assign wr_lane = wr_addr_i[1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ROM_WORDS; i++) mem[i] <= '0;
    end else if (wr_en_i) begin
      mem[wr_idx][{wr_lane, 3'b000} +: 8] <= wr_byte_i;
    end
  end

  assign rd_data_o = mem[rd_idx_i];

endmodule

// File: rtl/memctl_csr_file.sv
module memctl_csr_file
  import memctl_pkg::*;
#(
  parameter int CTRL_IDX  = 1,
  parameter int ARRAY_MB  = 2,
  parameter int ADDR_W    = 13,
  parameter int ROM_WORDS = 16,
  localparam int ROM_AW   = $clog2(ROM_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_mode_i,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [1:0]        req_size_i,
  input  logic [31:0]       req_wdata_i,
  input  logic [31:0]       err_set_c_i,
  input  logic [31:0]       err_set_d_i,
  input  logic              rom_wr_en_i,
  input  logic [ROM_AW+1:0] rom_wr_addr_i,
  input  logic [7:0]        rom_wr_byte_i,
  output logic              rsp_valid_o,
  output logic              wr_ack_o,
  output logic [31:0]       rsp_rdata_o,
  output logic              nxm_o,
  output logic              err_cnf_o
);

  reg_sel_e          sel;
  logic              bad_acc, nxm_hit, ext_q, acc_ok, wr_fire, rd_fire;
  logic [ROM_AW-1:0] rom_idx;
  logic [31:0]       rd_a, rd_b, rd_c, rd_d, rom_word, rd_mux;

  memctl_decode #(.ADDR_W(ADDR_W), .ROM_WORDS(ROM_WORDS)) u_dec (
    .addr_i   (req_addr_i),
    .size_i   (acc_size_e'(req_size_i)),
    .write_i  (req_write_i),
    .ext_i    (ext_q),
    .sel_o    (sel),
    .bad_o    (bad_acc),
    .nxm_o    (nxm_hit),
    .rom_idx_o(rom_idx)
  );

  assign acc_ok  = !bad_acc && !nxm_hit;
  assign wr_fire = req_valid_i && req_write_i && acc_ok;
  assign rd_fire = req_valid_i && !req_write_i && acc_ok;

  memctl_regs #(.CTRL_IDX(CTRL_IDX), .ARRAY_MB(ARRAY_MB)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .ext_mode_i(ext_mode_i),
    .wr_fire_i (wr_fire),
    .sel_i     (sel),
    .wdata_i   (req_wdata_i),
    .set_c_i   (err_set_c_i),
    .set_d_i   (err_set_d_i),
    .ext_q_o   (ext_q),
    .rd_a_o    (rd_a),
    .rd_b_o    (rd_b),
    .rd_c_o    (rd_c),
    .rd_d_o    (rd_d)
  );

  memctl_rom #(.ROM_WORDS(ROM_WORDS)) u_rom (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en_i  (rom_wr_en_i),
    .wr_addr_i(rom_wr_addr_i),
    .wr_byte_i(rom_wr_byte_i),
    .rd_idx_i (rom_idx),
    .rd_data_o(rom_word)
  );

  always_comb begin
    case (sel)
      SEL_A:   rd_mux = rd_a;
      SEL_B:   rd_mux = rd_b;
      SEL_C:   rd_mux = rd_c;
      SEL_D:   rd_mux = rd_d;
      SEL_ROM: rd_mux = rom_word;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_o <= 1'b0;
      wr_ack_o    <= 1'b0;
      nxm_o       <= 1'b0;
      err_cnf_o   <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= req_valid_i && !req_write_i;
      wr_ack_o    <= req_valid_i && req_write_i;
      nxm_o       <= req_valid_i && !bad_acc && nxm_hit;
      err_cnf_o   <= req_valid_i && bad_acc;
      rsp_rdata_o <= rd_fire ? rd_mux : '0;
    end
  end

  // R4: refusal pulse rides on a handshake with zero data
  p_err_handshake_r4: assert property (@(posedge clk) disable iff (!rst_n)
    err_cnf_o |-> ((rsp_valid_o || wr_ack_o) && (rsp_rdata_o == 32'd0)));

  // R12: missing-location pulse rides on a handshake, never with a refusal
  p_nxm_handshake_r12: assert property (@(posedge clk) disable iff (!rst_n)
    nxm_o |-> ((rsp_valid_o || wr_ack_o) && !err_cnf_o && (rsp_rdata_o == 32'd0)));

  // R12: every read request is answered in the next cycle
  p_read_answer_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && !req_write_i) |=> (rsp_valid_o && !wr_ack_o));

  // R12: no handshake without a request
  p_no_spurious_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid_i |=> (!rsp_valid_o && !wr_ack_o && !nxm_o && !err_cnf_o));

endmodule

// File: tb/memctl_csr_file_tb_top.sv
module memctl_csr_file_tb_top;

  localparam int CTRL_IDX  = 1;
  localparam int ARRAY_MB  = 2;
  localparam int ADDR_W    = 13;
  localparam int ROM_WORDS = 16;
  localparam int ROM_AW    = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              ext_mode_i = 1'b0;
  logic              req_valid_i = 1'b0;
  logic              req_write_i = 1'b0;
  logic [ADDR_W-1:0] req_addr_i = '0;
  logic [1:0]        req_size_i = 2'd2;
  logic [31:0]       req_wdata_i = '0;
  logic [31:0]       err_set_c_i = '0;
  logic [31:0]       err_set_d_i = '0;
  logic              rom_wr_en_i = 1'b0;
  logic [ROM_AW+1:0] rom_wr_addr_i = '0;
  logic [7:0]        rom_wr_byte_i = '0;
  logic              rsp_valid_o, wr_ack_o, nxm_o, err_cnf_o;
  logic [31:0]       rsp_rdata_o;

  memctl_csr_file #(.CTRL_IDX(CTRL_IDX), .ARRAY_MB(ARRAY_MB), .ADDR_W(ADDR_W),
                    .ROM_WORDS(ROM_WORDS)) dut_i (.*);

  always #10 clk = ~clk;

  // behavioural reference state
  logic [31:0] m_a, m_b, m_c, m_d;
  logic [31:0] m_rom [ROM_WORDS];
  bit          m_ext;
  bit          e_rv, e_wa, e_nxm, e_err;
  logic [31:0] e_rd;
  int          n_cmp = 0, n_bad = 0, cyc = 0;
  logic [31:0] seed = 32'h1234_5678;

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog expired at cycle %0d (actual=hung expected=done)", cyc);
      summary();
      $finish;
    end
  end

  task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] xs(logic [31:0] s);
    logic [31:0] t = s;
    t = t ^ (t << 13);
    t = t ^ (t >> 17);
    t = t ^ (t << 5);
    return t;
  endfunction

  task automatic model(bit v, bit w, int addr, int sz, logic [31:0] wd,
                       logic [31:0] sc, logic [31:0] sd, bit rwe, int raddr, logic [7:0] rb);
    int ofs;
    logic [31:0] keep, take, clr;
    e_rv = v && !w; e_wa = v && w; e_nxm = 0; e_err = 0; e_rd = 0;
    clr = m_ext ? 32'h300C_0380 : 32'h3000_0000;
    if (v) begin
      ofs = addr / 4;
      if ((addr % 4) != 0 || sz != 2) e_err = 1;
      else if (ofs >= 1024) begin
        if (w || (ofs - 1024) >= ROM_WORDS) e_nxm = 1;
        else e_rd = m_rom[ofs - 1024];
      end else if (ofs == 3 && !m_ext) e_nxm = 1;
      else if (ofs > 3) e_nxm = 1;
      else if (!w) begin
        if (ofs == 0) e_rd = m_a & 32'h0010_7FFF;
        if (ofs == 1) e_rd = (m_b & ~32'h0000_0800) | 32'h0000_3000;
        if (ofs == 2) e_rd = m_c & (m_ext ? 32'h700C_0380 : 32'h7FFF_FFFF);
        if (ofs == 3) e_rd = m_d & 32'h700C_0380;
      end else begin
        if (ofs == 0) begin
          take = wd[8] ? 32'h107 : 32'h100;
          m_a = (m_a & ~take) | (wd & take);
        end
        if (ofs == 1) begin
          take = wd[14] ? 32'h0FFF_C3FF : 32'h0000_43FF;
          m_b = (m_b & ~take) | (wd & take);
        end
        if (ofs == 2) begin
          m_c[30] = wd[30];
          keep = ~(wd & clr);
          m_c = m_c & keep;
        end
        if (ofs == 3) begin
          m_d[30] = wd[30];
          m_d = m_d & ~(wd & 32'h300C_0380);
        end
      end
    end
    m_c = m_c | (sc & 32'hBFFF_FFFF);
    if (m_ext) m_d = m_d | (sd & 32'hBFFF_FFFF);
    if (rwe) m_rom[raddr / 4][(raddr % 4) * 8 +: 8] = rb;
  endtask

  task automatic step(string tag, bit v, bit w, int addr, int sz = 2,
                      logic [31:0] wd = 0, logic [31:0] sc = 0, logic [31:0] sd = 0,
                      bit rwe = 0, int raddr = 0, logic [7:0] rb = 0);
    req_valid_i = v; req_write_i = w; req_addr_i = ADDR_W'(addr);
    req_size_i = 2'(sz); req_wdata_i = wd; err_set_c_i = sc; err_set_d_i = sd;
    rom_wr_en_i = rwe; rom_wr_addr_i = (ROM_AW+2)'(raddr); rom_wr_byte_i = rb;
    model(v, w, addr, sz, wd, sc, sd, rwe, raddr, rb);
    @(posedge clk);
    @(negedge clk);
    req_valid_i = 0; err_set_c_i = 0; err_set_d_i = 0; rom_wr_en_i = 0;
    cmp(tag, "rsp_valid", 32'(rsp_valid_o), 32'(e_rv));
    cmp(tag, "wr_ack",    32'(wr_ack_o),    32'(e_wa));
    cmp(tag, "nxm",       32'(nxm_o),       32'(e_nxm));
    cmp(tag, "err_cnf",   32'(err_cnf_o),   32'(e_err));
    cmp(tag, "rdata",     rsp_rdata_o,      e_rd);
  endtask

  task automatic rd(string tag, int ofs);
    step(tag, 1, 0, ofs * 4);
  endtask

  task automatic wr(string tag, int ofs, logic [31:0] wd);
    step(tag, 1, 1, ofs * 4, 2, wd);
  endtask

  task automatic do_reset(string tag, bit ext);
    @(negedge clk);
    rst_n = 0; ext_mode_i = ext; req_valid_i = 0; rom_wr_en_i = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    m_ext = ext;
    m_a = ext ? ((ARRAY_MB - 1) * 512 + 32'h6A) : 32'h7E10;
    m_b = ext ? (32'h3000 + CTRL_IDX * ARRAY_MB * (1 << 19)) : (32'h3000 + CTRL_IDX * (1 << 21));
    m_c = 0; m_d = 0;
    for (int i = 0; i < ROM_WORDS; i++) m_rom[i] = 0;
    cmp(tag, "idle rsp_valid", 32'(rsp_valid_o), 0);
    cmp(tag, "idle wr_ack",    32'(wr_ack_o), 0);
    cmp(tag, "idle nxm",       32'(nxm_o), 0);
    cmp(tag, "idle err_cnf",   32'(err_cnf_o), 0);
  endtask

  task automatic rand_phase(string tag, int n);
    for (int k = 0; k < n; k++) begin
      logic [31:0] r, wd, sc, sd;
      int kind, addr, sz;
      seed = xs(seed); r = seed;
      seed = xs(seed); wd = seed;
      sc = 0; sd = 0;
      if (r[20:18] == 3'd0) begin
        seed = xs(seed); sc = seed;
        seed = xs(seed); sd = seed & sc;
        sc = sc & wd;
      end
      kind = int'(r[2:0]);
      sz = 2;
      case (kind)
        0, 1, 2, 3: addr = kind * 4;
        4:          addr = (4 + int'(r[15:8])) * 4;
        5:          addr = (1024 + int'(r[15:8]) % 20) * 4;
        6: begin    addr = int'(r[12:8]) * 4 + int'(r[17:16]); sz = int'(r[22:21]); end
        default:    addr = int'(r[9:8]) * 4;
      endcase
      step(tag, r[30] | r[29], r[3], addr, sz, wd, sc, sd, kind == 7 || r[25],
           int'(r[31:26]), r[23:16]);
    end
  endtask

  initial begin
    // ---------------- basic build ----------------
    do_reset("R1", 0);
    rd("R1", 0); rd("R1", 1); rd("R1", 2);
    rd("R9", 3);
    wr("R9", 3, 32'hFFFF_FFFF);
    rd("R9", 3);
    wr("R5", 0, 32'h0000_0105); rd("R5", 0);
    wr("R5", 0, 32'h0000_0003); rd("R5", 0);
    wr("R5", 0, 32'hFFFF_FFFF); rd("R5", 0);
    wr("R6", 1, 32'h0AAA_C3FF); rd("R6", 1);
    wr("R6", 1, 32'h0555_0155); rd("R6", 1);
    wr("R6", 1, 32'hFFFF_FFFF); rd("R6", 1);
    step("R13", 0, 0, 0, 2, 0, 32'hFFFF_FFFF); rd("R13", 2);
    wr("R7", 2, 32'h7000_0000); rd("R7", 2);
    wr("R7", 2, 32'h0000_0000); rd("R7", 2);
    step("R13", 1, 1, 8, 2, 32'h3000_0000, 32'h1000_0000); rd("R13", 2);
    step("R4", 1, 0, 2);
    step("R4", 1, 1, 0, 1, 32'h0000_0107);
    step("R4", 1, 1, 1, 2, 32'h0000_0107);
    step("R4", 1, 0, 4, 0);
    step("R4", 1, 1, 0, 3, 32'h0000_0107);
    rd("R4", 0);
    rd("R10", 4); wr("R10", 5, 32'hFFFF_FFFF); rd("R10", 1023);
    wr("R10", 1024, 32'hDEAD_BEEF); rd("R10", 1024);
    for (int l = 0; l < 4; l++) step("R11", 0, 0, 0, 2, 0, 0, 0, 1, l, 8'(8'hA1 + l));
    rd("R11", 1024);
    step("R11", 0, 0, 0, 2, 0, 0, 0, 1, 5 * 4 + 2, 8'h5C);
    step("R12", 1, 0, (1024 + 5) * 4, 2, 0, 0, 0, 1, 5 * 4 + 2, 8'h77);
    rd("R11", 1029);
    rd("R3", 1024 + ROM_WORDS - 1); rd("R3", 1024 + ROM_WORDS);
    rd("R12", 0); rd("R12", 1); rd("R12", 2); rd("R12", 1025);
    rand_phase("R12", 400);
    ext_mode_i = 1;
    rd("R14", 3); wr("R14", 3, 32'h4000_0000); rd("R14", 2);
    step("R14", 0, 0, 0, 2, 0, 32'hFFFF_FFFF); rd("R14", 2);
    // ---------------- extended build ----------------
    do_reset("R2", 1);
    rd("R2", 0); rd("R2", 1); rd("R2", 2); rd("R2", 3);
    step("R8", 0, 0, 0, 2, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    rd("R8", 2); rd("R8", 3);
    wr("R8", 3, 32'h5004_0100); rd("R8", 3);
    wr("R8", 2, 32'h7FFF_FFFF); rd("R8", 2);
    step("R13", 1, 1, 12, 2, 32'h0008_0080, 0, 32'h0008_0000); rd("R13", 3);
    ext_mode_i = 0;
    rd("R14", 3);
    rand_phase("R8", 400);
    summary();
    $finish;
  end

endmodule